// File: doc/BRIEF.md
# Low-Speed USB Packet Trigger

This block watches a low-speed USB line that has already been sampled at the bit rate. For each bit period it gets one strobe, with the line level (J or K) and a single-ended-zero flag. It undoes the NRZI coding and finds the start of a packet from the sync pattern. It then removes stuffed bits and collects the packet identifier and the field that follows it.

When the packet ends with an SE0, the block evaluates one trigger condition. The condition selects a packet class (token, data, handshake or error) and a subtype within that class. It can add a test on a field:

- an address relation or range test for non-SOF tokens,
- a frame number compared under a per-bit care mask for SOF,
- a relation or range test on the first payload byte for data packets.

A matching packet produces a one-clock trigger pulse that a capture engine can use. The configuration inputs are expected to stay static while packets are being received.

Top module: `usbt_trigger`

## Requirements
- R1: `line_k` is 1 for the K state and 0 for the J state. On each strobe without SE0, a level change decodes as bit 0 and an unchanged level decodes as bit 1. The reference level is J after reset and after every SE0 strobe.
- R2: A packet starts when the last eight decoded bits, oldest first, are 0,0,0,0,0,0,0,1. Starting from J, this is the line pattern KJKJKJKK. Bits decoded before that point are not part of any packet.
- R3: After six decoded 1s in a row, counting the final 1 of the sync, the next decoded bit is discarded. If that bit is 0, nothing else happens and the packet contents are unaffected.
- R4: Packet bits arrive least significant bit first. Bits 0-7 form the PID byte. The next 11 bits form the field, with address in field bits 0-6, endpoint in bits 7-10, frame number in bits 0-10, and first data byte in bits 0-7. The PID check passes only if at least 8 bits were received and PID bits 7:4 equal the complement of bits 3:0.
- R5: `trig` is high for exactly one clock. It rises in the clock after the first SE0 strobe that ends a packet, and only when the condition holds. An SE0 strobe while no packet is open never triggers.
- R6: `cfg_class`=0 selects tokens. Subtypes are 0 any, 1 SOF, 2 OUT, 3 IN, 4 SETUP. The PID low-nibble codes are OUT 0001, IN 1001, SOF 0101 and SETUP 1101. A token match needs a passing PID check, a good CRC5 and no stuffing error.
- R7: For non-SOF tokens the zero-extended address `v` is tested by `cfg_op` against `cfg_lo`/`cfg_hi`. The codes are 0 always, 1 v==lo, 2 v!=lo, 3 v<lo, 4 v<=lo, 5 v>lo, 6 v>=lo, 7 lo<=v<=hi, 8 v<lo or v>hi. Any other code never matches.
- R8: For an SOF token the frame number must equal `cfg_frame` on every bit set in `cfg_frame_care`. `cfg_op` has no effect on SOF packets.
- R9: `cfg_class`=1 selects data packets. Subtypes are 0 any, 1 DATA0 (0011), 2 DATA1 (1011). A match needs a passing PID check, at least 16 packet bits, no stuffing error, and the first data byte passing `cfg_op` as in R7.
- R10: `cfg_class`=2 selects handshakes. Subtypes are 0 any, 1 ACK (0010), 2 NAK (1010), 3 STALL (1110). A match needs a passing PID check and no stuffing error.
- R11: `cfg_class`=3 selects errors. Subtype 1 fires on a failed PID check, and subtype 0 fires on any of the three error kinds.
- R12: CRC5 runs over every bit after the PID, using polynomial x^5+x^2+1 and a seed of 11111. A token with a valid PID has a CRC5 error unless it holds exactly 24 bits and the residual is 01100. Error subtype 2 fires on a CRC5 error.
- R13: If the bit after six 1s is a 1, the packet has a stuffing error. Error subtype 3 fires on it, and it blocks every token, data and handshake match.
- R14: While `rst_n` is low, and in the first clock after it is released, `trig` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_vld | input | 1 | Strobe, one per recovered bit period |
| line_k | input | 1 | Line level at the strobe: 1 = K, 0 = J |
| line_se0 | input | 1 | Single-ended zero at the strobe |
| cfg_class | input | 2 | Packet class select |
| cfg_sub | input | 3 | Subtype within the class |
| cfg_op | input | 4 | Relation or range operator code |
| cfg_lo | input | 8 | Compare value / lower range bound |
| cfg_hi | input | 8 | Upper range bound |
| cfg_frame | input | 11 | SOF frame number to match |
| cfg_frame_care | input | 11 | Per-bit care mask for the frame number |
| trig | output | 1 | One-clock trigger pulse |

## Verification
Decoding, sync search, unstuffing and field collection all act on the strobe's own clock edge, and only the trigger itself is registered. The pulse is therefore due exactly one clock after the clock that sampled the terminating SE0 strobe, and it is gone by the following clock. The bench drives on falling edges and compares `trig` on every falling edge against a behavioural packet model. The model's verdict is armed only for the falling edge right after the SE0 strobe, so an early, late, doubled or missing pulse shows up as a mismatch in that exact cycle.

// File: rtl/usbt_pkg.sv
package usbt_pkg;
    localparam int PID_W    = 8;
    localparam int FLD_W    = 11;
    localparam int ADDR_W   = 7;
    localparam int VAL_W    = 8;
    localparam int CRC_W    = 5;
    localparam int CNT_W    = 7;
    localparam int TOK_BITS = PID_W + FLD_W + CRC_W;
    localparam int DAT_BITS = PID_W + VAL_W;

    localparam logic [7:0]       SYNC_PAT = 8'h80;
    localparam logic [CRC_W-1:0] CRC_SEED = 5'h1f;
    localparam logic [CRC_W-1:0] CRC_POLY = 5'h05;
    localparam logic [CRC_W-1:0] CRC_GOOD = 5'h0c;

    localparam logic [3:0] PID_OUT   = 4'b0001;
    localparam logic [3:0] PID_IN    = 4'b1001;
    localparam logic [3:0] PID_SOF   = 4'b0101;
    localparam logic [3:0] PID_SETUP = 4'b1101;
    localparam logic [3:0] PID_DATA0 = 4'b0011;
    localparam logic [3:0] PID_DATA1 = 4'b1011;
    localparam logic [3:0] PID_ACK   = 4'b0010;
    localparam logic [3:0] PID_NAK   = 4'b1010;
    localparam logic [3:0] PID_STALL = 4'b1110;

    typedef enum logic [1:0] {
        CLS_TOKEN = 2'd0,
        CLS_DATA  = 2'd1,
        CLS_HAND  = 2'd2,
        CLS_ERROR = 2'd3
    } cls_e;

    typedef enum logic [3:0] {
        OP_ALWAYS  = 4'd0,
        OP_EQ      = 4'd1,
        OP_NE      = 4'd2,
        OP_LT      = 4'd3,
        OP_LE      = 4'd4,
        OP_GT      = 4'd5,
        OP_GE      = 4'd6,
        OP_INSIDE  = 4'd7,
        OP_OUTSIDE = 4'd8
    } op_e;

    function automatic logic rel_ok(input logic [3:0] op, input logic [VAL_W-1:0] v,
                                    input logic [VAL_W-1:0] lo, input logic [VAL_W-1:0] hi);
        logic r;
        case (op)
            OP_ALWAYS:  r = 1'b1;
            OP_EQ:      r = (v == lo);
            OP_NE:      r = (v != lo);
            OP_LT:      r = (v < lo);
            OP_LE:      r = (v <= lo);
            OP_GT:      r = (v > lo);
            OP_GE:      r = (v >= lo);
            OP_INSIDE:  r = (v >= lo) && (v <= hi);
            OP_OUTSIDE: r = (v < lo) || (v > hi);
            default:    r = 1'b0;
        endcase
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c, input logic b);
        logic fb;
        fb = b ^ c[CRC_W-1];
        return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : {CRC_W{1'b0}});
    endfunction
endpackage

// File: rtl/usbt_line.sv
// NRZI decode, sync search and bit unstuffing; outputs act on the strobe cycle.
module usbt_line #(
    parameter int         RUN  = 6,
    parameter logic [7:0] SYNC = 8'h80
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb,
    input  logic line_k,
    input  logic se0,
    output logic sop,
    output logic eop,
    output logic dv,
    output logic db,
    output logic stuff_err
);
    localparam int OW = $clog2(RUN + 1);

    typedef struct packed {
        logic          hunt;
        logic          prev_k;
        logic [7:0]    sr;
        logic [OW-1:0] ones;
        logic          serr;
    } line_st_t;

    localparam line_st_t LINE_RST = '{hunt: 1'b1, prev_k: 1'b0, sr: 8'hff,
                                      ones: {OW{1'b0}}, serr: 1'b0};

    line_st_t st_q, st_d;
    logic       dec;
    logic [7:0] sr_n;

    always_comb begin
        st_d = st_q;
        sop  = 1'b0;
        eop  = 1'b0;
        dv   = 1'b0;
        db   = 1'b0;
        dec  = (line_k == st_q.prev_k);
        sr_n = {dec, st_q.sr[7:1]};
        if (stb) begin
            if (se0) begin
                eop         = !st_q.hunt;
                st_d.hunt   = 1'b1;
                st_d.prev_k = 1'b0;
                st_d.sr     = 8'hff;
                st_d.ones   = '0;
            end else begin
                st_d.prev_k = line_k;
                if (st_q.hunt) begin
                    st_d.sr = sr_n;
                    if (sr_n == SYNC) begin
                        sop       = 1'b1;
                        st_d.hunt = 1'b0;
                        st_d.sr   = 8'hff;
                        st_d.ones = OW'(1);   // the sync ends in a single one
                        st_d.serr = 1'b0;
                    end
                end else if (st_q.ones == OW'(RUN)) begin
                    st_d.ones = '0;
                    if (dec) st_d.serr = 1'b1;
                end else begin
                    dv        = 1'b1;
                    db        = dec;
                    st_d.ones = dec ? st_q.ones + 1'b1 : '0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= LINE_RST;
        else        st_q <= st_d;
    end

    assign stuff_err = st_q.serr;
endmodule

// File: rtl/usbt_fields.sv
// Collects PID, field and running CRC5 of the open packet.
module usbt_fields
    import usbt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sop,
    input  logic             dv,
    input  logic             db,
    output logic [CNT_W-1:0] nbits,
    output logic [PID_W-1:0] pid,
    output logic [FLD_W-1:0] fld,
    output logic [CRC_W-1:0] crc
);
    localparam int PI_W = $clog2(PID_W);
    localparam int FI_W = $clog2(FLD_W);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [PID_W-1:0] pid;
        logic [FLD_W-1:0] fld;
        logic [CRC_W-1:0] crc;
    } fld_st_t;

    localparam fld_st_t FLD_RST = '{cnt: '0, pid: '0, fld: '0, crc: CRC_SEED};

    fld_st_t          st_q, st_d;
    logic [CNT_W-1:0] off;

    always_comb begin
        st_d = st_q;
        off  = st_q.cnt - CNT_W'(PID_W);
        if (sop) begin
            st_d = FLD_RST;
        end else if (dv) begin
            if (st_q.cnt < CNT_W'(PID_W)) begin
                st_d.pid[st_q.cnt[PI_W-1:0]] = db;
            end else begin
                st_d.crc = crc_step(st_q.crc, db);
                if (off < CNT_W'(FLD_W)) st_d.fld[off[FI_W-1:0]] = db;
            end
            if (st_q.cnt != {CNT_W{1'b1}}) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= FLD_RST;
        else        st_q <= st_d;
    end

    assign nbits = st_q.cnt;
    assign pid   = st_q.pid;
    assign fld   = st_q.fld;
    assign crc   = st_q.crc;
endmodule

// File: rtl/usbt_match.sv
// Evaluates the configured trigger condition against a completed packet.
module usbt_match
    import usbt_pkg::*;
(
    input  logic [CNT_W-1:0] nbits,
    input  logic [PID_W-1:0] pid,
    input  logic [FLD_W-1:0] fld,
    input  logic [CRC_W-1:0] crc,
    input  logic             stuff_err,
    input  logic [1:0]       cfg_class,
    input  logic [2:0]       cfg_sub,
    input  logic [3:0]       cfg_op,
    input  logic [VAL_W-1:0] cfg_lo,
    input  logic [VAL_W-1:0] cfg_hi,
    input  logic [FLD_W-1:0] cfg_frame,
    input  logic [FLD_W-1:0] cfg_frame_care,
    output logic             hit
);
    logic       pid_ok, is_tok, is_dat, is_hs, crc_ok;
    logic       pid_err, crc_err;
    logic       sub_ok, fld_ok;
    logic [3:0] nib;
    logic [VAL_W-1:0] addr_v;

    always_comb begin
        nib     = pid[3:0];
        pid_ok  = (nbits >= CNT_W'(PID_W)) && (pid[PID_W-1:4] == ~pid[3:0]);
        is_tok  = (nib == PID_OUT) || (nib == PID_IN) || (nib == PID_SOF) || (nib == PID_SETUP);
        is_dat  = (nib == PID_DATA0) || (nib == PID_DATA1);
        is_hs   = (nib == PID_ACK) || (nib == PID_NAK) || (nib == PID_STALL);
        crc_ok  = (nbits == CNT_W'(TOK_BITS)) && (crc == CRC_GOOD);
        pid_err = !pid_ok;
        crc_err = pid_ok && is_tok && !crc_ok;
        addr_v  = VAL_W'(fld[ADDR_W-1:0]);
        sub_ok  = 1'b0;
        fld_ok  = 1'b0;
        hit     = 1'b0;
        case (cls_e'(cfg_class))
            CLS_TOKEN: begin
                case (cfg_sub)
                    3'd0:    sub_ok = 1'b1;
                    3'd1:    sub_ok = (nib == PID_SOF);
                    3'd2:    sub_ok = (nib == PID_OUT);
                    3'd3:    sub_ok = (nib == PID_IN);
                    3'd4:    sub_ok = (nib == PID_SETUP);
                    default: sub_ok = 1'b0;
                endcase
                if (nib == PID_SOF) fld_ok = ((fld ^ cfg_frame) & cfg_frame_care) == '0;
                else                fld_ok = rel_ok(cfg_op, addr_v, cfg_lo, cfg_hi);
                hit = pid_ok && is_tok && crc_ok && !stuff_err && sub_ok && fld_ok;
            end
            CLS_DATA: begin
                case (cfg_sub)
                    3'd0:    sub_ok = 1'b1;
                    3'd1:    sub_ok = (nib == PID_DATA0);
                    3'd2:    sub_ok = (nib == PID_DATA1);
                    default: sub_ok = 1'b0;
                endcase
                fld_ok = rel_ok(cfg_op, fld[VAL_W-1:0], cfg_lo, cfg_hi);
                hit = pid_ok && is_dat && !stuff_err && (nbits >= CNT_W'(DAT_BITS))
                      && sub_ok && fld_ok;
            end
            CLS_HAND: begin
                case (cfg_sub)
                    3'd0:    sub_ok = 1'b1;
                    3'd1:    sub_ok = (nib == PID_ACK);
                    3'd2:    sub_ok = (nib == PID_NAK);
                    3'd3:    sub_ok = (nib == PID_STALL);
                    default: sub_ok = 1'b0;
                endcase
                hit = pid_ok && is_hs && !stuff_err && sub_ok;
            end
            default: begin
                case (cfg_sub)
                    3'd0:    hit = pid_err || crc_err || stuff_err;
                    3'd1:    hit = pid_err;
                    3'd2:    hit = crc_err;
                    3'd3:    hit = stuff_err;
                    default: hit = 1'b0;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/usbt_trigger.sv
module usbt_trigger
    import usbt_pkg::*;
#(
    parameter int STUFF_RUN = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld,
    input  logic              line_k,
    input  logic              line_se0,
    input  logic [1:0]        cfg_class,
    input  logic [2:0]        cfg_sub,
    input  logic [3:0]        cfg_op,
    input  logic [VAL_W-1:0]  cfg_lo,
    input  logic [VAL_W-1:0]  cfg_hi,
    input  logic [FLD_W-1:0]  cfg_frame,
    input  logic [FLD_W-1:0]  cfg_frame_care,
    output logic              trig
);
    typedef struct packed {
        logic trig;
    } top_st_t;

    logic             sop_w, eop_w, dv_w, db_w, serr_w, hit_w;
    logic [CNT_W-1:0] nbits_w;
    logic [PID_W-1:0] pid_w;
    logic [FLD_W-1:0] fld_w;
    logic [CRC_W-1:0] crc_w;
    top_st_t          st_q, st_d;

    usbt_line #(.RUN(STUFF_RUN), .SYNC(SYNC_PAT)) u_line (
        .clk(clk), .rst_n(rst_n), .stb(bit_vld), .line_k(line_k), .se0(line_se0),
        .sop(sop_w), .eop(eop_w), .dv(dv_w), .db(db_w), .stuff_err(serr_w)
    );

    usbt_fields u_fields (
        .clk(clk), .rst_n(rst_n), .sop(sop_w), .dv(dv_w), .db(db_w),
        .nbits(nbits_w), .pid(pid_w), .fld(fld_w), .crc(crc_w)
    );

    usbt_match u_match (
        .nbits(nbits_w), .pid(pid_w), .fld(fld_w), .crc(crc_w), .stuff_err(serr_w),
        .cfg_class(cfg_class), .cfg_sub(cfg_sub), .cfg_op(cfg_op),
        .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
        .cfg_frame(cfg_frame), .cfg_frame_care(cfg_frame_care), .hit(hit_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trig = eop_w && hit_w;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trig = st_q.trig;
endmodule

// File: rtl/usbt_trigger_chk.sv
module usbt_trigger_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_vld,
    input logic line_se0,
    input logic trig,
    input logic sop,
    input logic eop,
    input logic dv
);
    assert_trig_after_end_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig |-> $past(bit_vld && line_se0));

    assert_trig_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> !trig);

    assert_end_on_se0_R5: assert property (@(posedge clk) disable iff (!rst_n)
        eop |-> (bit_vld && line_se0));

    assert_sync_not_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sop |-> !dv);

    assert_data_on_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dv |-> (bit_vld && !line_se0));

    assert_quiet_after_reset_R14: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !trig);
endmodule

bind usbt_trigger usbt_trigger_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .line_se0(line_se0),
    .trig(trig), .sop(sop_w), .eop(eop_w), .dv(dv_w)
);

// File: tb/usbt_trigger_test.sv
module usbt_trigger_test;
    localparam logic [3:0] P_OUT = 4'b0001, P_IN = 4'b1001, P_SOF = 4'b0101, P_SETUP = 4'b1101;
    localparam logic [3:0] P_D0 = 4'b0011, P_D1 = 4'b1011;
    localparam logic [3:0] P_ACK = 4'b0010, P_NAK = 4'b1010, P_STALL = 4'b1110;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0, bit_vld = 1'b0, line_k = 1'b0, line_se0 = 1'b0;
    logic [1:0]  cfg_class = '0;
    logic [2:0]  cfg_sub = '0;
    logic [3:0]  cfg_op = '0;
    logic [7:0]  cfg_lo = '0, cfg_hi = '0;
    logic [10:0] cfg_frame = '0, cfg_frame_care = '0;
    logic        trig;

    usbt_trigger uut (
        .clk(clk), .rst_n(rst_n), .bit_vld(bit_vld), .line_k(line_k), .line_se0(line_se0),
        .cfg_class(cfg_class), .cfg_sub(cfg_sub), .cfg_op(cfg_op), .cfg_lo(cfg_lo),
        .cfg_hi(cfg_hi), .cfg_frame(cfg_frame), .cfg_frame_care(cfg_frame_care), .trig(trig)
    );

    int    total = 0, bad = 0;
    logic  exp_pending = 1'b0;
    string cur_tag = "R14";
    logic  lvl = 1'b0;
    logic  pk[$];
    bit    finished = 0;

    task automatic chk(input bit ok, input string tag, input logic a, input logic e);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0b expected=%0b at %0t", tag, a, e, $time);
        end
    endtask

    // every clock: compare against the model, then drive the next inputs
    task automatic tick(input logic v, input logic k, input logic s);
        @(negedge clk);
        chk(trig === exp_pending, cur_tag, trig, exp_pending);
        exp_pending = 1'b0;
        bit_vld = v; line_k = k; line_se0 = s;
    endtask

    task automatic strobe(input logic k, input logic s);
        tick(1'b1, k, s);
        repeat (3) tick(1'b0, k, s);
    endtask

    task automatic send_dec(input logic d);   // R1: a zero toggles the line
        if (!d) lvl = ~lvl;
        strobe(lvl, 1'b0);
    endtask

    task automatic put(input int unsigned v, input int n);
        for (int i = 0; i < n; i++) pk.push_back(v[i]);
    endtask

    task automatic mk_pid(input logic [3:0] p);
        pk.delete();
        put({24'd0, ~p, p}, 8);
    endtask

    task automatic mk_tok(input logic [3:0] p, input logic [10:0] f, input bit bad_crc, input bit trunc);
        logic [4:0] c;
        logic fb;
        mk_pid(p);
        put({21'd0, f}, 11);
        c = 5'h1f;
        for (int i = 0; i < 11; i++) begin
            fb = f[i] ^ c[4];
            c = {c[3:0], 1'b0} ^ (fb ? 5'h05 : 5'h00);
        end
        c = ~c;
        if (bad_crc) c[2] = ~c[2];
        for (int i = 4; i >= 0; i--) pk.push_back(c[i]);
        if (trunc) void'(pk.pop_back());
    endtask

    task automatic mk_dat(input logic [3:0] p, input logic [7:0] b0, input logic [7:0] b1);
        mk_pid(p);
        put({24'd0, b0}, 8);
        put({24'd0, b1}, 8);
    endtask

    function automatic logic relop(input logic [3:0] op, input int v, input int lo, input int hi);
        case (op)
            4'd0: return 1'b1;
            4'd1: return v == lo;
            4'd2: return v != lo;
            4'd3: return v < lo;
            4'd4: return v <= lo;
            4'd5: return v > lo;
            4'd6: return v >= lo;
            4'd7: return (v >= lo) && (v <= hi);
            4'd8: return (v < lo) || (v > hi);
            default: return 1'b0;
        endcase
    endfunction

    // behavioural verdict for one packet, from the requirements
    function automatic logic model(input bit serr);
        int n;
        logic [7:0]  p;
        logic [10:0] f;
        logic [4:0]  c;
        logic [3:0]  nb;
        logic fb, pok, tok, dat, hs, cok, sub, fm;
        n = pk.size(); p = '0; f = '0; c = 5'h1f;
        for (int i = 0; i < n; i++) begin
            if (i < 8) p[i] = pk[i];
            else begin
                if (i < 19) f[i-8] = pk[i];
                fb = pk[i] ^ c[4];
                c = {c[3:0], 1'b0} ^ (fb ? 5'h05 : 5'h00);
            end
        end
        nb  = p[3:0];
        pok = (n >= 8) && (p[7:4] == ~p[3:0]);
        tok = (nb == P_OUT) || (nb == P_IN) || (nb == P_SOF) || (nb == P_SETUP);
        dat = (nb == P_D0) || (nb == P_D1);
        hs  = (nb == P_ACK) || (nb == P_NAK) || (nb == P_STALL);
        cok = (n == 24) && (c == 5'b01100);
        case (cfg_class)
            2'd0: begin
                sub = (cfg_sub == 0) || (cfg_sub == 1 && nb == P_SOF) || (cfg_sub == 2 && nb == P_OUT)
                   || (cfg_sub == 3 && nb == P_IN) || (cfg_sub == 4 && nb == P_SETUP);
                if (nb == P_SOF) fm = ((f ^ cfg_frame) & cfg_frame_care) == 11'd0;
                else             fm = relop(cfg_op, int'(f[6:0]), int'(cfg_lo), int'(cfg_hi));
                return pok && tok && cok && !serr && sub && fm;
            end
            2'd1: begin
                sub = (cfg_sub == 0) || (cfg_sub == 1 && nb == P_D0) || (cfg_sub == 2 && nb == P_D1);
                fm = relop(cfg_op, int'(f[7:0]), int'(cfg_lo), int'(cfg_hi));
                return pok && dat && !serr && (n >= 16) && sub && fm;
            end
            2'd2: begin
                sub = (cfg_sub == 0) || (cfg_sub == 1 && nb == P_ACK) || (cfg_sub == 2 && nb == P_NAK)
                   || (cfg_sub == 3 && nb == P_STALL);
                return pok && hs && !serr && sub;
            end
            default: begin
                case (cfg_sub)
                    3'd0: return !pok || (pok && tok && !cok) || serr;
                    3'd1: return !pok;
                    3'd2: return pok && tok && !cok;
                    3'd3: return serr;
                    default: return 1'b0;
                endcase
            end
        endcase
    endfunction

    task automatic send_packet(input bit brk, input int pre, input string tag);
        int  ones;
        bit  broke;
        cur_tag = tag;
        lvl = 1'b0;
        repeat (3) strobe(1'b0, 1'b0);
        for (int i = 0; i < pre; i++) send_dec((i % 3) == 0);   // R2: noise before sync
        for (int i = 0; i < 7; i++) send_dec(1'b0);
        send_dec(1'b1);
        ones = 1; broke = 0;
        foreach (pk[i]) begin
            send_dec(pk[i]);
            ones = pk[i] ? ones + 1 : 0;
            if (ones == 6) begin                                  // R3
                if (brk && !broke) begin send_dec(1'b1); broke = 1; end
                else send_dec(1'b0);
                ones = 0;
            end
        end
        tick(1'b1, 1'b0, 1'b1);
        exp_pending = model(broke);
        repeat (3) tick(1'b0, 1'b0, 1'b1);
        strobe(1'b0, 1'b1);
        lvl = 1'b0;
        repeat (2) strobe(1'b0, 1'b0);
    endtask

    task automatic cfg(input logic [1:0] c, input logic [2:0] s, input logic [3:0] o,
                       input logic [7:0] lo, input logic [7:0] hi);
        cfg_class = c; cfg_sub = s; cfg_op = o; cfg_lo = lo; cfg_hi = hi;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R14: reset state
        repeat (4) tick(1'b0, 1'b0, 1'b0);
        rst_n = 1'b1;
        tick(1'b0, 1'b0, 1'b0);
        chk(trig === 1'b0, "R14", trig, 1'b0);

        // R1 R4 R6: OUT token, any token
        cfg(2'd0, 3'd0, 4'd0, 8'd0, 8'd0);
        mk_tok(P_OUT, {4'd2, 7'd5}, 0, 0); send_packet(0, 0, "R1 R4 R6 out any");
        cfg(2'd0, 3'd3, 4'd0, 8'd0, 8'd0); send_packet(0, 0, "R6 in vs out");
        cfg(2'd0, 3'd2, 4'd0, 8'd0, 8'd0); send_packet(0, 0, "R6 out");
        mk_tok(P_SETUP, {4'd0, 7'd0}, 0, 0);
        cfg(2'd0, 3'd4, 4'd0, 8'd0, 8'd0); send_packet(0, 0, "R6 setup");
        mk_tok(P_IN, {4'd1, 7'd100}, 0, 0);
        cfg(2'd0, 3'd3, 4'd0, 8'd0, 8'd0); send_packet(0, 0, "R6 in");
        cfg(2'd2, 3'd0, 4'd0, 8'd0, 8'd0); send_packet(0, 0, "R6 R10 token not handshake");

        // R7: every operator, two windows
        mk_tok(P_OUT, {4'd2, 7'd5}, 0, 0);
        for (int op = 1; op <= 9; op++) begin
            cfg(2'd0, 3'd0, op[3:0], 8'd5, 8'd7); send_packet(0, 0, "R7 op window 5..7");
            cfg(2'd0, 3'd0, op[3:0], 8'd6, 8'd9); send_packet(0, 0, "R7 op window 6..9");
        end

        // R8: SOF frame with care mask; operator ignored
        mk_tok(P_SOF, 11'h5a3, 0, 0);
        cfg(2'd0, 3'd1, 4'd1, 8'd99, 8'd0);
        cfg_frame = 11'h5a0; cfg_frame_care = 11'h7f0; send_packet(0, 0, "R8 frame masked match");
        cfg_frame = 11'h4a0; send_packet(0, 0, "R8 frame mismatch");
        cfg_frame_care = 11'h000; send_packet(0, 0, "R8 all dont care");
        cfg_frame = 11'h5a3; cfg_frame_care = 11'h7ff; send_packet(0, 0, "R8 exact");

        // R9: data packets
        mk_dat(P_D1, 8'h42, 8'h13);
        cfg(2'd1, 3'd2, 4'd5, 8'h40, 8'h00); send_packet(0, 0, "R9 data1 gt");
        cfg(2'd1, 3'd1, 4'd5, 8'h40, 8'h00); send_packet(0, 0, "R9 data0 vs data1");
        cfg(2'd1, 3'd0, 4'd3, 8'h40, 8'h00); send_packet(0, 0, "R9 lt fails");
        cfg(2'd1, 3'd0, 4'd7, 8'h42, 8'h42); send_packet(0, 0, "R9 inside");
        mk_pid(P_D0); put(32'h42, 4);
        cfg(2'd1, 3'd0, 4'd0, 8'h00, 8'h00); send_packet(0, 0, "R9 short data");

        // R10: handshakes
        for (int s = 0; s <= 4; s++) begin
            cfg(2'd2, s[2:0], 4'd0, 8'd0, 8'd0);
            mk_pid(P_ACK);   send_packet(0, 0, "R10 ack");
            mk_pid(P_NAK);   send_packet(0, 0, "R10 nak");
            mk_pid(P_STALL); send_packet(0, 0, "R10 stall");
        end

        // R11: PID check failure
        pk.delete(); put(32'h03, 8); put(32'h55, 8);
        cfg(2'd3, 3'd1, 4'd0, 8'd0, 8'd0); send_packet(0, 0, "R11 pid error");
        cfg(2'd3, 3'd0, 4'd0, 8'd0, 8'd0); send_packet(0, 0, "R11 any error");
        cfg(2'd1, 3'd0, 4'd0, 8'd0, 8'd0); send_packet(0, 0, "R11 bad pid not data");
        mk_pid(P_ACK);
        cfg(2'd3, 3'd0, 4'd0, 8'd0, 8'd0); send_packet(0, 0, "R11 clean packet no error");

        // R12: CRC5 errors
        mk_tok(P_OUT, {4'd3, 7'd17}, 1, 0);
        cfg(2'd3, 3'd2, 4'd0, 8'd0, 8'd0); send_packet(0, 0, "R12 crc error");
        cfg(2'd0, 3'd0, 4'd0, 8'd0, 8'd0); send_packet(0, 0, "R12 bad crc not token");
        mk_tok(P_OUT, {4'd3, 7'd17}, 0, 1);
        cfg(2'd3, 3'd2, 4'd0, 8'd0, 8'd0); send_packet(0, 0, "R12 short token");
        mk_tok(P_OUT, {4'd3, 7'd17}, 0, 0); send_packet(0, 0, "R12 good crc no error");

        // R3 R13: stuffing
        mk_dat(P_D0, 8'hff, 8'hff);
        cfg(2'd1, 3'd0, 4'd1, 8'hff, 8'h00); send_packet(0, 0, "R3 stuffed data intact");
        cfg(2'd3, 3'd3, 4'd0, 8'd0, 8'd0);  send_packet(0, 0, "R3 R13 no violation");
        send_packet(1, 0, "R13 stuff violation");
        cfg(2'd1, 3'd0, 4'd0, 8'd0, 8'd0);  send_packet(1, 0, "R13 violation blocks data");
        mk_tok(P_OUT, {4'hf, 7'h7f}, 0, 0);
        cfg(2'd0, 3'd0, 4'd1, 8'h7f, 8'h00); send_packet(0, 0, "R3 stuffed token");

        // R2: noise before sync
        mk_pid(P_NAK);
        cfg(2'd2, 3'd2, 4'd0, 8'd0, 8'd0); send_packet(0, 7, "R2 noise then sync");

        // R5: SE0 while idle never triggers
        cfg(2'd3, 3'd0, 4'd0, 8'd0, 8'd0);
        cur_tag = "R5 idle se0";
        repeat (4) strobe(1'b0, 1'b1);
        repeat (4) strobe(1'b0, 1'b0);
        tick(1'b0, 1'b0, 1'b0);
        chk(trig === 1'b0, "R5 idle se0 final", trig, 1'b0);

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule